// File: doc/BRIEF.md
# Two-Channel Digital PLL Lock Detector

This block judges whether each of two phase-locked loops (a main "RF" loop and an auxiliary "IF" loop) is in lock. For each loop it watches the reference and feedback pulses that reach the phase detector. It counts the sample-clock ticks between the two edges of every comparison and feeds that count to a lock state machine with hysteresis. A narrow entry window must be met on several comparisons in a row before lock is declared. Once locked, the loop stays locked until one comparison exceeds a wider exit window, which is twice the entry window.

Every input pulse is one sample-clock cycle wide and synchronous to `clk`. For high comparison rates, the RF channel can thin its comparison events so that only every fourth reference pulse and every fourth feedback pulse is measured. The IF channel ignores this control. A per-loop power-down input forces that loop's lock flag low. A start-over pulse, issued when the divider value is rewritten, clears the good-run counters and any declared lock and keeps the windows. A combined flag reports lock only when both loops are locked.

Each lock state machine has three states. S_OFF means powered down. S_HUNT means the machine is counting a run of good comparisons. S_LOCKED means lock is declared. Its transitions are T_POWER_DOWN (any state to S_OFF while power-down is high), T_WAKE (S_OFF to S_HUNT on release), T_ACQUIRE (S_HUNT to S_LOCKED on the fifth good comparison in a row), T_SLIP (S_LOCKED to S_HUNT on an error above the exit window) and T_RESTART (any powered state to S_HUNT on the start-over pulse). The phase-measurement machine has three states. M_IDLE waits for a first edge. M_WAIT_FB is entered after the reference arrives first, and M_WAIT_REF after the feedback arrives first. Its transitions are T_FIRST (M_IDLE to a wait state), T_PAIR (a wait state to M_IDLE when the opposite edge arrives) and T_REPEAT (a wait state to itself when the same edge repeats).

Top module: `pll_lock_detect`

## Requirements
- R1: The phase error of a comparison is the number of `clk` cycles between the reference pulse and the feedback pulse, whichever comes first. Pulses in the same cycle give an error of 0.
- R2: A lock flag rises only after RUN_LEN (default 5) consecutive comparisons whose error is strictly less than the entry window (defaults: 4 ticks for RF, 6 ticks for IF). After reset all three lock outputs are low.
- R3: While hunting, a comparison with an error equal to or greater than the entry window resets the good-run count to zero. An error of entry-1 counts as good.
- R4: A locked channel stays locked for errors up to and including the exit window (2 × entry window: 8 ticks for RF, 12 ticks for IF). It drops lock on the first comparison whose error exceeds the exit window.
- R5: While `div4_en` is high, the RF channel measures only the first of every four reference pulses and the first of every four feedback pulses. The skipped pulses have no effect on `rf_lock`. The IF channel measures every pulse regardless of `div4_en`.
- R6: While a channel's power-down input is high, its lock flag is low. After release the channel hunts from a zero good-run count.
- R7: `both_lock` is high only when `rf_lock` and `if_lock` are both high.
- R8: A `restart` pulse clears both lock flags, both good-run counts, the RF divide-by-4 phase and any measurement in progress. The windows are unchanged.
- R9: If the same edge arrives twice before the opposite edge, the pending comparison completes with a saturated error (bad in both windows). The new edge then starts a fresh measurement.
- R10: An error count saturates at 2^CNT_W-1 (default 31) ticks. Such a comparison is bad in both windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; sets the tick size of phase error |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_ref | input | 1 | RF reference pulse, one cycle wide |
| rf_fb | input | 1 | RF feedback pulse, one cycle wide |
| if_ref | input | 1 | IF reference pulse, one cycle wide |
| if_fb | input | 1 | IF feedback pulse, one cycle wide |
| div4_en | input | 1 | Thin RF comparison events to one in four |
| rf_pd | input | 1 | RF loop powered down |
| if_pd | input | 1 | IF loop powered down |
| restart | input | 1 | Start-over pulse on a divider write |
| rf_lock | output | 1 | RF loop locked |
| if_lock | output | 1 | IF loop locked |
| both_lock | output | 1 | Both loops locked |

## Verification
The assertions check a set of relations on every cycle. Simultaneous edges yield a zero error. A repeated edge yields a saturated error. Lock can only rise after a good comparison. A locked channel holds within the exit window and drops beyond it. A channel leaving power-down starts unlocked. A start-over pulse clears both flags. The bench scenarios are needed for the behaviour that spans many comparisons. These scenarios cover the exact count of five good comparisons, the run reset exactly at the entry boundary, the swept errors on both sides of each window in both edge orders, the one-in-four thinning of RF events with IF unaffected, and recovery after power-down.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;
    localparam int NUM_PLL = 2;
    localparam int CH_RF   = 0;
    localparam int CH_IF   = 1;

    typedef enum logic [1:0] {
        S_OFF    = 2'd0,
        S_HUNT   = 2'd1,
        S_LOCKED = 2'd2
    } lock_state_e;

    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_WAIT_FB  = 2'd1,
        M_WAIT_REF = 2'd2
    } meas_state_e;
endpackage

// File: rtl/ld_event_gate.sv
`timescale 1ns/1ps
module ld_event_gate #(
    parameter bit DIV_CAPABLE = 1'b1,
    parameter int DIV_RATIO   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic div_en_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic ref_o,
    output logic fb_o
);
    localparam int PH_W = $clog2(DIV_RATIO);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);

    logic            div_on;
    logic [PH_W-1:0] ref_ph, fb_ph;

    assign div_on = DIV_CAPABLE && div_en_i;

    // Phase counters: position of each edge within its group of DIV_RATIO
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ph <= '0;
            fb_ph  <= '0;
        end else if (restart_i || !div_on) begin
            ref_ph <= '0;
            fb_ph  <= '0;
        end else begin
            if (ref_i) ref_ph <= (ref_ph == PH_LAST) ? '0 : ref_ph + 1'b1;
            if (fb_i)  fb_ph  <= (fb_ph  == PH_LAST) ? '0 : fb_ph  + 1'b1;
        end
    end

    always_comb begin
        ref_o = ref_i && (!div_on || ref_ph == '0);
        fb_o  = fb_i  && (!div_on || fb_ph  == '0);
    end

    // R5: a pulse arriving mid-group while thinning is never passed on
    a_r5_skip_mid_group: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && ref_i && !restart_i && ref_ph == '0) |=> !(div_on && ref_o && !restart_i));
endmodule

// File: rtl/ld_phase_meas.sv
`timescale 1ns/1ps
module ld_phase_meas
    import ld_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             ref_i,
    input  logic             fb_i,
    output logic             done_o,
    output logic [CNT_W-1:0] err_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    meas_state_e      state, nxt_state;
    logic [CNT_W-1:0] cnt, nxt_cnt;
    logic [CNT_W-1:0] nxt_err;
    logic             nxt_done;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = (cnt == MAXV) ? MAXV : cnt + 1'b1;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt_inc;
        nxt_err   = err_o;
        nxt_done  = 1'b0;
        unique case (state)
            M_IDLE: begin
                nxt_cnt = '0;
                if (ref_i && fb_i) begin          // T_PAIR with zero error
                    nxt_done = 1'b1;
                    nxt_err  = '0;
                end else if (ref_i) begin         // T_FIRST
                    nxt_state = M_WAIT_FB;
                    nxt_cnt   = CNT_W'(1);
                end else if (fb_i) begin          // T_FIRST
                    nxt_state = M_WAIT_REF;
                    nxt_cnt   = CNT_W'(1);
                end
            end
            M_WAIT_FB: begin
                if (fb_i) begin                   // T_PAIR
                    nxt_state = M_IDLE;
                    nxt_done  = 1'b1;
                    nxt_err   = cnt;
                end else if (ref_i) begin         // T_REPEAT
                    nxt_done  = 1'b1;
                    nxt_err   = MAXV;
                    nxt_cnt   = CNT_W'(1);
                end
            end
            M_WAIT_REF: begin
                if (ref_i) begin                  // T_PAIR
                    nxt_state = M_IDLE;
                    nxt_done  = 1'b1;
                    nxt_err   = cnt;
                end else if (fb_i) begin          // T_REPEAT
                    nxt_done  = 1'b1;
                    nxt_err   = MAXV;
                    nxt_cnt   = CNT_W'(1);
                end
            end
            default: begin
                nxt_state = M_IDLE;
                nxt_cnt   = '0;
            end
        endcase
        if (restart_i) begin
            nxt_state = M_IDLE;
            nxt_cnt   = '0;
            nxt_done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= M_IDLE;
            cnt    <= '0;
            err_o  <= '0;
            done_o <= 1'b0;
        end else begin
            state  <= nxt_state;
            cnt    <= nxt_cnt;
            err_o  <= nxt_err;
            done_o <= nxt_done;
        end
    end

    // R1: coincident edges report a zero error on the next cycle
    a_r1_same_cycle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_IDLE && ref_i && fb_i && !restart_i) |=> (done_o && err_o == '0));

    // R9: a repeated reference before feedback completes as saturated
    a_r9_repeat_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_WAIT_FB && ref_i && !fb_i && !restart_i) |=> (done_o && err_o == MAXV));

    // R8: a start-over pulse suppresses the completion that would follow it
    a_r8_restart_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !done_o);
endmodule

// File: rtl/ld_lock_fsm.sv
`timescale 1ns/1ps
module ld_lock_fsm
    import ld_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int ENTRY   = 4,
    parameter int EXIT    = 8,
    parameter int RUN_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_i,
    input  logic             restart_i,
    input  logic             done_i,
    input  logic [CNT_W-1:0] err_i,
    output logic             lock_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] ENTRY_LIM = CNT_W'(ENTRY);
    localparam logic [CNT_W-1:0] EXIT_LIM  = CNT_W'(EXIT);

    lock_state_e      state, nxt_state;
    logic [RUN_W-1:0] run, nxt_run;
    logic             good_entry, bad_exit;

    assign good_entry = done_i && (err_i < ENTRY_LIM);
    assign bad_exit   = done_i && (err_i > EXIT_LIM);

    always_comb begin
        nxt_state = state;
        nxt_run   = run;
        unique case (state)
            S_OFF: begin
                nxt_run = '0;
                if (!pd_i) nxt_state = S_HUNT;              // T_WAKE
            end
            S_HUNT: begin
                if (good_entry) begin
                    if (run == RUN_LAST) begin              // T_ACQUIRE
                        nxt_state = S_LOCKED;
                        nxt_run   = '0;
                    end else begin
                        nxt_run = run + 1'b1;
                    end
                end else if (done_i) begin
                    nxt_run = '0;
                end
            end
            S_LOCKED: begin
                nxt_run = '0;
                if (bad_exit) nxt_state = S_HUNT;           // T_SLIP
            end
            default: begin
                nxt_state = S_HUNT;
                nxt_run   = '0;
            end
        endcase
        if (restart_i) begin                                // T_RESTART
            nxt_state = S_HUNT;
            nxt_run   = '0;
        end
        if (pd_i) begin                                     // T_POWER_DOWN
            nxt_state = S_OFF;
            nxt_run   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HUNT;
            run   <= '0;
        end else begin
            state <= nxt_state;
            run   <= nxt_run;
        end
    end

    always_comb begin
        lock_o = (state == S_LOCKED) && !pd_i;
    end

    // R2: lock can only rise right after a comparison inside the entry window
    a_r2_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(done_i && err_i < ENTRY_LIM));

    // R4: an error beyond the exit window drops lock
    a_r4_slip_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && done_i && err_i > EXIT_LIM) |=> !lock_o);

    // R4: inside the exit window lock is kept
    a_r4_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !(done_i && err_i > EXIT_LIM) && !restart_i) |=> (lock_o || pd_i));

    // R6: on release from power-down the channel is not locked
    a_r6_wake_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_i) && !pd_i) |-> !lock_o);
endmodule

// File: rtl/pll_lock_detect.sv
`timescale 1ns/1ps
module pll_lock_detect
    import ld_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int RF_ENTRY = 4,
    parameter int IF_ENTRY = 6,
    parameter int RUN_LEN  = 5,
    parameter int RF_DIV   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rf_ref,
    input  logic rf_fb,
    input  logic if_ref,
    input  logic if_fb,
    input  logic div4_en,
    input  logic rf_pd,
    input  logic if_pd,
    input  logic restart,
    output logic rf_lock,
    output logic if_lock,
    output logic both_lock
);
    logic [NUM_PLL-1:0] ref_v, fb_v, pd_v, lock_v;

    assign ref_v = {if_ref, rf_ref};
    assign fb_v  = {if_fb,  rf_fb};
    assign pd_v  = {if_pd,  rf_pd};

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_ch
        localparam int ENTRY = (g == CH_RF) ? RF_ENTRY : IF_ENTRY;
        localparam int EXIT  = 2 * ENTRY;

        logic             ref_ev, fb_ev, done;
        logic [CNT_W-1:0] err;

        ld_event_gate #(
            .DIV_CAPABLE (g == CH_RF),
            .DIV_RATIO   (RF_DIV)
        ) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart),
            .div_en_i  (div4_en),
            .ref_i     (ref_v[g]),
            .fb_i      (fb_v[g]),
            .ref_o     (ref_ev),
            .fb_o      (fb_ev)
        );

        ld_phase_meas #(
            .CNT_W (CNT_W)
        ) u_meas (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (restart),
            .ref_i     (ref_ev),
            .fb_i      (fb_ev),
            .done_o    (done),
            .err_o     (err)
        );

        ld_lock_fsm #(
            .CNT_W   (CNT_W),
            .ENTRY   (ENTRY),
            .EXIT    (EXIT),
            .RUN_LEN (RUN_LEN)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .pd_i      (pd_v[g]),
            .restart_i (restart),
            .done_i    (done),
            .err_i     (err),
            .lock_o    (lock_v[g])
        );
    end

    assign rf_lock   = lock_v[CH_RF];
    assign if_lock   = lock_v[CH_IF];
    assign both_lock = &lock_v;

    // R8: a start-over pulse leaves both channels unlocked
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!rf_lock && !if_lock));
endmodule

// File: tb/pll_lock_detect_bench.sv
`timescale 1ns/1ps
module pll_lock_detect_bench;
    localparam int RUN = 5;
    localparam int ENT [2] = '{4, 6};
    localparam int SATV = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rf_ref = 0, rf_fb = 0, if_ref = 0, if_fb = 0;
    logic div4_en = 0, rf_pd = 0, if_pd = 0, restart = 0;
    logic rf_lock, if_lock, both_lock;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit mlock [2];
    int mrun  [2];
    int mdiv;
    bit mdiv4;

    always #2.5 clk = ~clk;

    pll_lock_detect u_pll_lock_detect (
        .clk(clk), .rst_n(rst_n), .rf_ref(rf_ref), .rf_fb(rf_fb),
        .if_ref(if_ref), .if_fb(if_fb), .div4_en(div4_en), .rf_pd(rf_pd),
        .if_pd(if_pd), .restart(restart), .rf_lock(rf_lock),
        .if_lock(if_lock), .both_lock(both_lock)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " rf_lock"}, rf_lock, mlock[0]);
        check({req, " if_lock"}, if_lock, mlock[1]);
        check({req, " R7 both_lock"}, both_lock, mlock[0] && mlock[1]);
    endtask

    function automatic void model(input int ch, input int err);
        int e;
        e = (err > SATV) ? SATV : err;
        if (ch == 0 && mdiv4) begin
            mdiv = (mdiv + 1) % 4;
            if (mdiv != 1) return;
        end
        if (!mlock[ch]) begin
            if (e < ENT[ch]) begin
                mrun[ch]++;
                if (mrun[ch] == RUN) begin
                    mlock[ch] = 1;
                    mrun[ch]  = 0;
                end
            end else begin
                mrun[ch] = 0;
            end
        end else if (e > 2 * ENT[ch]) begin
            mlock[ch] = 0;
        end
    endfunction

    task automatic drive(input int ch, input logic r, input logic f);
        if (ch == 0) begin rf_ref = r; rf_fb = f; end
        else         begin if_ref = r; if_fb = f; end
    endtask

    // one comparison: first edge, then the other k cycles later
    task automatic compare(input int ch, input bit ref_first, input int k);
        for (int i = 0; i <= k; i++) begin
            @(negedge clk);
            if (k == 0)            drive(ch, 1, 1);
            else if (i == 0)       drive(ch, ref_first, !ref_first);
            else if (i == k)       drive(ch, !ref_first, ref_first);
            else                   drive(ch, 0, 0);
        end
        @(negedge clk);
        drive(ch, 0, 0);
        repeat (3) @(negedge clk);
        model(ch, k);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart = 1;
        @(negedge clk);
        restart = 0;
        @(negedge clk);
        mlock = '{0, 0};
        mrun  = '{0, 0};
        mdiv  = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        mlock = '{0, 0};
        mrun  = '{0, 0};
        mdiv  = 0;
        mdiv4 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R2 reset");

        // R1 R2 R3: hunting sweep, errors around the entry window, both orders
        for (int ch = 0; ch < 2; ch++)
            for (int o = 0; o < 2; o++)
                for (int e = 0; e <= ENT[ch] + 1; e++) begin
                    do_restart();
                    for (int j = 0; j < RUN - 1; j++) compare(ch, o[0], 1);
                    check_all("R2 four good not yet locked");
                    compare(ch, o[0], e);
                    check_all("R3 R1 fifth comparison boundary");
                    compare(ch, o[0], 0);
                    check_all("R3 run after boundary");
                end

        // R4: locked sweep, errors around the exit window
        for (int ch = 0; ch < 2; ch++)
            for (int o = 0; o < 2; o++)
                for (int e = 0; e <= 2 * ENT[ch] + 2; e++) begin
                    do_restart();
                    for (int j = 0; j < RUN; j++) compare(ch, o[0], 0);
                    check_all("R2 locked after five");
                    compare(ch, o[0], e);
                    check_all("R4 exit window");
                end

        // R9: repeated reference before feedback
        do_restart();
        for (int j = 0; j < RUN - 1; j++) compare(0, 1, 1);
        @(negedge clk); rf_ref = 1;
        @(negedge clk); rf_ref = 0;
        repeat (2) @(negedge clk);
        rf_ref = 1;
        @(negedge clk); rf_ref = 0; rf_fb = 1;
        @(negedge clk); rf_fb = 0;
        repeat (3) @(negedge clk);
        model(0, SATV);
        model(0, 1);
        check_all("R9 repeated edge resets run");

        // R10: saturated error while locked
        do_restart();
        for (int j = 0; j < RUN; j++) compare(1, 0, 2);
        compare(1, 0, 40);
        check_all("R10 saturated error drops lock");

        // R5: thinning on RF only
        @(negedge clk);
        div4_en = 1;
        mdiv4   = 1;
        do_restart();
        for (int grp = 0; grp < RUN; grp++) begin
            compare(0, 1, 1);
            for (int j = 0; j < 3; j++) compare(0, 1, 20);
            check_all("R5 skipped RF events ignored");
        end
        for (int grp = 0; grp < 2; grp++) begin
            compare(1, 1, 1);
            compare(1, 1, 20);
        end
        check_all("R5 IF not thinned");
        @(negedge clk);
        div4_en = 0;
        mdiv4   = 0;

        // R6: power-down of one channel
        do_restart();
        for (int j = 0; j < RUN; j++) begin compare(0, 1, 2); compare(1, 0, 3); end
        check_all("R6 both locked before power-down");
        @(negedge clk); rf_pd = 1;
        @(negedge clk);
        mlock[0] = 0; mrun[0] = 0;
        check_all("R6 rf forced low");
        rf_pd = 0;
        repeat (2) @(negedge clk);
        check_all("R6 low after release");
        for (int j = 0; j < RUN - 1; j++) compare(0, 0, 1);
        check_all("R6 re-hunt not yet locked");
        compare(0, 0, 1);
        check_all("R6 relocked after five");

        // R8: restart clears and windows unchanged
        do_restart();
        check_all("R8 restart clears lock");
        for (int j = 0; j < RUN - 1; j++) compare(0, 1, ENT[0] - 1);
        check_all("R8 count restarted");
        compare(0, 1, ENT[0] - 1);
        check_all("R8 windows kept");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule